// File: doc/BRIEF.md
# Streaming 6502 Instruction Decoder

This block turns a stream of bytes from 6502 program memory into one record per instruction. Each byte arrives with its memory address over a valid/ready handshake. A start pulse loads a start address and an end address, and the block then waits for the opcode that sits at the start address. Each opcode is split into a group field, an addressing-mode field and an operation field. Small per-group rules turn those fields into a mnemonic code and an addressing-mode code. The block then collects the operand bytes that the mode needs.

Each record carries the following:
- the opcode address
- the mnemonic code and the mode code
- the raw operand bytes
- the instruction length
- a resolved 16-bit value: the operand itself, or the branch target for relative mode

The record waits on a valid/ready handshake, and no input is taken while it waits. The instruction that starts at or past the end address is the last one. After it, the block pulses `done` and goes back to idle.

Top module: `op6502_stream_decoder`

## Requirements
- R1: Opcode fields are group = bits 1:0, mode field = bits 4:2, operation = bits 7:5. Group 1 mnemonics by operation 0..7 are ORA=1, AND=2, EOR=3, ADC=4, STA=5, LDA=6, CMP=7, SBC=8. The group 1 mode field 0..7 gives modes 6, 3, 1, 2, 7, 8, 10, 9.
- R2: The mode codes are imm=1, abs=2, zp=3, acc=4, imp=5, (zp,X)=6, (zp),Y=7, zp,X=8, abs,X=9, abs,Y=10, rel=11, ind=12, zp,Y=13, with 0 meaning invalid. `rec_len` is the opcode plus its operand bytes: 3 for modes 2, 9, 10 and 12; 1 for modes 0, 4 and 5; 2 otherwise.
- R3: Group 0 decodes as follows:
  - Mode field 0: BRK=17, RTI=19 and RTS=20 implied; JSR=18 absolute; LDY=21, CPY=22 and CPX=23 immediate.
  - Mode field 1: BIT=24, STY=26, LDY, CPY and CPX, all zero page.
  - Mode field 2: PHP=27, PLP=28, PHA=29, PLA=30, DEY=31, TAY=32, INY=33 and INX=34, all implied.
  - Mode field 3: BIT, JMP=25, STY, LDY, CPY and CPX absolute, except that JMP with operation 3 is indirect.
  - Mode field 4: the branches BPL..BEQ=35..42, relative.
  - Mode field 6: CLC, SEC, CLI, SEI, TYA, CLV, CLD and SED=43..50, implied.
  - Every other cell is invalid.
- R4: Group 2 decodes as follows:
  - Operations 0..7 are ASL..INC=9..16.
  - Mode fields 1, 3, 5 and 7 are zero page, absolute, zp,X and abs,X. STX and LDX use zp,Y in mode field 5. LDX uses abs,Y in mode field 7, and STX is invalid there.
  - Mode field 0 is valid only for LDX, immediate.
  - Mode field 2 gives the accumulator shifts for operations 0..3, and TXA=51, TAX=52 and DEX=53 (implied) for operations 4..6.
  - Mode field 6 gives only TXS=54 and TSX=55 (implied).
  - Mode field 4 is invalid.
- R5: Every group 3 opcode, every other invalid cell, and opcode 0x89 give mnemonic 0, mode 0 and length 1, and consume only the opcode byte.
- R6: Two-byte operands arrive low byte first, and the value is {hi, lo}. A one-byte operand, outside relative mode, gives the value {0x00, lo}. With no operand, the value and both operand bytes are 0.
- R7: In relative mode the value is the opcode address + 2 + the sign-extended operand, modulo 2^16.
- R8: After reset the block is idle and `in_ready`, `rec_valid` and `done` are low. After a start pulse, bytes whose address differs from the start address are taken and dropped until the opcode at the start address arrives. The first record carries the start address.
- R9: The instruction whose opcode address is at or above the end address is the last. One cycle after its record is accepted, `done` is high for exactly one cycle. Afterwards `in_ready` stays low until the next start.
- R10: While `rec_valid` is high and `rec_ready` is low, `in_ready` is low and every record field holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Loads the start and end addresses while idle |
| start_addr | input | 16 | Address of the first opcode |
| end_addr | input | 16 | Opcode address that ends the run |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block takes a byte |
| in_addr | input | 16 | Address of the input byte |
| in_byte | input | 8 | Input byte |
| rec_valid | output | 1 | Record present |
| rec_ready | input | 1 | Consumer takes the record |
| rec_addr | output | 16 | Opcode address |
| rec_mnem | output | 6 | Mnemonic code, 0 = invalid |
| rec_mode | output | 4 | Addressing-mode code, 0 = invalid |
| rec_op_lo | output | 8 | First operand byte |
| rec_op_hi | output | 8 | Second operand byte |
| rec_len | output | 2 | Instruction length in bytes |
| rec_value | output | 16 | Resolved operand or branch target |
| done | output | 1 | One-cycle pulse after the last record |

## Verification
The assertions check these behaviours on every cycle:
- A stalled record stays frozen, and input is blocked while it waits.
- Invalid and operand-free records carry length 1 and a zero value.
- Absolute-class modes always report three bytes.
- `done` follows only an accepted record and is followed by idle.

Only the bench scenarios can show the rest:
- the decode of each group's regular and corrected cells;
- the branch target arithmetic, including the wrap past 0xFFFF;
- bytes dropped before the start address;
- a run that ends because the end address lies below the start.

// File: rtl/op6502_stream_decoder.sv
module op6502_stream_decoder (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] start_addr,
  input  logic [15:0] end_addr,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [15:0] in_addr,
  input  logic [7:0]  in_byte,
  output logic        rec_valid,
  input  logic        rec_ready,
  output logic [15:0] rec_addr,
  output logic [5:0]  rec_mnem,
  output logic [3:0]  rec_mode,
  output logic [7:0]  rec_op_lo,
  output logic [7:0]  rec_op_hi,
  output logic [1:0]  rec_len,
  output logic [15:0] rec_value,
  output logic        done
);

  localparam logic [3:0] M_NONE = 4'd0;
  localparam logic [3:0] M_IMM  = 4'd1;
  localparam logic [3:0] M_ABS  = 4'd2;
  localparam logic [3:0] M_ZP   = 4'd3;
  localparam logic [3:0] M_ACC  = 4'd4;
  localparam logic [3:0] M_IMP  = 4'd5;
  localparam logic [3:0] M_IZX  = 4'd6;
  localparam logic [3:0] M_IZY  = 4'd7;
  localparam logic [3:0] M_ZPX  = 4'd8;
  localparam logic [3:0] M_ABX  = 4'd9;
  localparam logic [3:0] M_ABY  = 4'd10;
  localparam logic [3:0] M_REL  = 4'd11;
  localparam logic [3:0] M_IND  = 4'd12;
  localparam logic [3:0] M_ZPY  = 4'd13;

  localparam logic [5:0] N_BAD = 6'd0;
  localparam logic [5:0] N_BRK = 6'd17;
  localparam logic [5:0] N_JSR = 6'd18;
  localparam logic [5:0] N_RTI = 6'd19;
  localparam logic [5:0] N_RTS = 6'd20;
  localparam logic [5:0] N_LDY = 6'd21;
  localparam logic [5:0] N_CPY = 6'd22;
  localparam logic [5:0] N_CPX = 6'd23;
  localparam logic [5:0] N_BIT = 6'd24;
  localparam logic [5:0] N_JMP = 6'd25;
  localparam logic [5:0] N_STY = 6'd26;
  localparam logic [5:0] N_PHP = 6'd27;
  localparam logic [5:0] N_BPL = 6'd35;
  localparam logic [5:0] N_CLC = 6'd43;
  localparam logic [5:0] N_TXA = 6'd51;
  localparam logic [5:0] N_TAX = 6'd52;
  localparam logic [5:0] N_DEX = 6'd53;
  localparam logic [5:0] N_TXS = 6'd54;
  localparam logic [5:0] N_TSX = 6'd55;
  localparam logic [5:0] N_G1  = 6'd1;
  localparam logic [5:0] N_G2  = 6'd9;

  typedef enum logic [2:0] {
    S_IDLE, S_SEEK, S_OP, S_B1, S_B2, S_OUT, S_DONE
  } st_t;

  st_t         st;
  logic [15:0] start_q, end_q;
  logic        last_q;
  logic [1:0]  grp;
  logic [2:0]  mf, opf;
  logic [5:0]  dm;
  logic [3:0]  dmode;
  logic [1:0]  dlen;
  logic        take_op;

  assign grp = in_byte[1:0];
  assign mf  = in_byte[4:2];
  assign opf = in_byte[7:5];

  always_comb begin
    dm    = N_BAD;
    dmode = M_NONE;
    case (grp)
      2'd1: begin
        dm = N_G1 + {3'b000, opf};
        case (mf)
          3'd0: dmode = M_IZX;
          3'd1: dmode = M_ZP;
          3'd2: dmode = M_IMM;
          3'd3: dmode = M_ABS;
          3'd4: dmode = M_IZY;
          3'd5: dmode = M_ZPX;
          3'd6: dmode = M_ABY;
          default: dmode = M_ABX;
        endcase
        if (opf == 3'd4 && mf == 3'd2) begin
          dm    = N_BAD;
          dmode = M_NONE;
        end
      end
      2'd0: begin
        case (mf)
          3'd0: begin
            case (opf)
              3'd0: begin dm = N_BRK; dmode = M_IMP; end
              3'd1: begin dm = N_JSR; dmode = M_ABS; end
              3'd2: begin dm = N_RTI; dmode = M_IMP; end
              3'd3: begin dm = N_RTS; dmode = M_IMP; end
              3'd5: begin dm = N_LDY; dmode = M_IMM; end
              3'd6: begin dm = N_CPY; dmode = M_IMM; end
              3'd7: begin dm = N_CPX; dmode = M_IMM; end
              default: ;
            endcase
          end
          3'd1, 3'd3: begin
            dmode = (mf == 3'd1) ? M_ZP : M_ABS;
            case (opf)
              3'd1: dm = N_BIT;
              3'd2: dm = (mf == 3'd3) ? N_JMP : N_BAD;
              3'd3: begin
                dm = (mf == 3'd3) ? N_JMP : N_BAD;
                dmode = (mf == 3'd3) ? M_IND : M_ZP;
              end
              3'd4: dm = N_STY;
              3'd5: dm = N_LDY;
              3'd6: dm = N_CPY;
              3'd7: dm = N_CPX;
              default: dm = N_BAD;
            endcase
            if (dm == N_BAD) dmode = M_NONE;
          end
          3'd2: begin dm = N_PHP + {3'b000, opf}; dmode = M_IMP; end
          3'd4: begin dm = N_BPL + {3'b000, opf}; dmode = M_REL; end
          3'd6: begin dm = N_CLC + {3'b000, opf}; dmode = M_IMP; end
          default: ;
        endcase
      end
      2'd2: begin
        dm = N_G2 + {3'b000, opf};
        case (mf)
          3'd0: dmode = (opf == 3'd5) ? M_IMM : M_NONE;
          3'd1: dmode = M_ZP;
          3'd2: begin
            case (opf)
              3'd4: begin dm = N_TXA; dmode = M_IMP; end
              3'd5: begin dm = N_TAX; dmode = M_IMP; end
              3'd6: begin dm = N_DEX; dmode = M_IMP; end
              3'd7: dmode = M_NONE;
              default: dmode = M_ACC;
            endcase
          end
          3'd3: dmode = M_ABS;
          3'd5: dmode = (opf == 3'd4 || opf == 3'd5) ? M_ZPY : M_ZPX;
          3'd6: begin
            case (opf)
              3'd4: begin dm = N_TXS; dmode = M_IMP; end
              3'd5: begin dm = N_TSX; dmode = M_IMP; end
              default: dmode = M_NONE;
            endcase
          end
          3'd7: begin
            case (opf)
              3'd4: dmode = M_NONE;
              3'd5: dmode = M_ABY;
              default: dmode = M_ABX;
            endcase
          end
          default: dmode = M_NONE;
        endcase
        if (dmode == M_NONE) dm = N_BAD;
      end
      default: ;
    endcase
  end

  always_comb begin
    case (dmode)
      M_NONE, M_ACC, M_IMP:         dlen = 2'd1;
      M_ABS, M_ABX, M_ABY, M_IND:   dlen = 2'd3;
      default:                      dlen = 2'd2;
    endcase
  end

  assign in_ready  = (st == S_SEEK) || (st == S_OP) || (st == S_B1) || (st == S_B2);
  assign rec_valid = (st == S_OUT);
  assign done      = (st == S_DONE);
  assign take_op   = in_valid && ((st == S_OP) || (st == S_SEEK && in_addr == start_q));

  always_comb begin
    if (rec_mode == M_REL)
      rec_value = rec_addr + 16'd2 + {{8{rec_op_lo[7]}}, rec_op_lo};
    else if (rec_len == 2'd3)
      rec_value = {rec_op_hi, rec_op_lo};
    else if (rec_len == 2'd2)
      rec_value = {8'h00, rec_op_lo};
    else
      rec_value = 16'h0000;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      start_q   <= 16'h0000;
      end_q     <= 16'h0000;
      last_q    <= 1'b0;
      rec_addr  <= 16'h0000;
      rec_mnem  <= 6'd0;
      rec_mode  <= 4'd0;
      rec_len   <= 2'd0;
      rec_op_lo <= 8'h00;
      rec_op_hi <= 8'h00;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          start_q <= start_addr;
          end_q   <= end_addr;
          st      <= S_SEEK;
        end
        S_SEEK, S_OP: if (take_op) begin
          rec_addr  <= in_addr;
          rec_mnem  <= dm;
          rec_mode  <= dmode;
          rec_len   <= dlen;
          rec_op_lo <= 8'h00;
          rec_op_hi <= 8'h00;
          last_q    <= (in_addr >= end_q);
          st        <= (dlen == 2'd1) ? S_OUT : S_B1;
        end
        S_B1: if (in_valid) begin
          rec_op_lo <= in_byte;
          st        <= (rec_len == 2'd2) ? S_OUT : S_B2;
        end
        S_B2: if (in_valid) begin
          rec_op_hi <= in_byte;
          st        <= S_OUT;
        end
        S_OUT: if (rec_ready) st <= last_q ? S_DONE : S_OP;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R10
  hold_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_ready |=> rec_valid && !in_ready && $stable(rec_addr)
      && $stable(rec_mnem) && $stable(rec_mode) && $stable(rec_value));

  // R5
  bad_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && rec_mode == M_NONE |-> rec_len == 2'd1 && rec_mnem == N_BAD);

  // R2
  long_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && (rec_mode == M_ABS || rec_mode == M_ABX || rec_mode == M_ABY
      || rec_mode == M_IND) |-> rec_len == 2'd3);

  // R6
  no_opnd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && rec_len == 2'd1 |-> rec_value == 16'h0000 && rec_op_lo == 8'h00
      && rec_op_hi == 8'h00);

  // R9
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(rec_valid && rec_ready));

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !in_ready && !rec_valid);

endmodule

// File: tb/op6502_stream_decoder_test.sv
module op6502_stream_decoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 30;
  // opcode, operand lo, operand hi, mnemonic, mode
  localparam logic [39:0] VEC [0:NV-1] = '{
    {8'h65, 8'h10, 8'h00, 8'd4,  8'd3},
    {8'h1D, 8'h34, 8'h12, 8'd1,  8'd9},
    {8'h81, 8'h20, 8'h00, 8'd5,  8'd6},
    {8'h89, 8'h00, 8'h00, 8'd0,  8'd0},
    {8'h20, 8'hCD, 8'hAB, 8'd18, 8'd2},
    {8'h60, 8'h00, 8'h00, 8'd20, 8'd5},
    {8'hA0, 8'h7E, 8'h00, 8'd21, 8'd1},
    {8'h6C, 8'hFC, 8'hFF, 8'd25, 8'd12},
    {8'h4C, 8'h00, 8'h80, 8'd25, 8'd2},
    {8'hD0, 8'hFC, 8'h00, 8'd41, 8'd11},
    {8'h10, 8'h05, 8'h00, 8'd35, 8'd11},
    {8'h78, 8'h00, 8'h00, 8'd46, 8'd5},
    {8'h94, 8'h00, 8'h00, 8'd0,  8'd0},
    {8'hA2, 8'h99, 8'h00, 8'd14, 8'd1},
    {8'h82, 8'h00, 8'h00, 8'd0,  8'd0},
    {8'h0A, 8'h00, 8'h00, 8'd9,  8'd4},
    {8'hAA, 8'h00, 8'h00, 8'd52, 8'd5},
    {8'hEA, 8'h00, 8'h00, 8'd0,  8'd0},
    {8'h96, 8'h44, 8'h00, 8'd13, 8'd13},
    {8'hB6, 8'h45, 8'h00, 8'd14, 8'd13},
    {8'hBE, 8'h00, 8'h30, 8'd14, 8'd10},
    {8'h9E, 8'h00, 8'h00, 8'd0,  8'd0},
    {8'hFE, 8'h11, 8'h22, 8'd16, 8'd9},
    {8'h9A, 8'h00, 8'h00, 8'd54, 8'd5},
    {8'h03, 8'h00, 8'h00, 8'd0,  8'd0},
    {8'hB1, 8'h80, 8'h00, 8'd6,  8'd7},
    {8'h24, 8'hF0, 8'h00, 8'd24, 8'd3},
    {8'h08, 8'h00, 8'h00, 8'd27, 8'd5},
    {8'h1E, 8'h02, 8'h01, 8'd9,  8'd9},
    {8'h9C, 8'h00, 8'h00, 8'd0,  8'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [15:0] start_addr = '0, end_addr = '0, in_addr = '0;
  logic in_valid = 1'b0, rec_ready = 1'b1;
  logic [7:0] in_byte = '0;
  logic in_ready, rec_valid, done;
  logic [15:0] rec_addr, rec_value;
  logic [5:0] rec_mnem;
  logic [3:0] rec_mode;
  logic [7:0] rec_op_lo, rec_op_hi;
  logic [1:0] rec_len;

  int checks = 0, fails = 0, nrec = 0, ndone = 0;
  logic finished = 1'b0;
  logic [15:0] r_addr [0:63];
  logic [15:0] r_val  [0:63];
  logic [5:0]  r_mn   [0:63];
  logic [3:0]  r_md   [0:63];
  logic [1:0]  r_len  [0:63];

  op6502_stream_decoder uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .end_addr(end_addr), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_byte(in_byte), .rec_valid(rec_valid),
    .rec_ready(rec_ready), .rec_addr(rec_addr), .rec_mnem(rec_mnem),
    .rec_mode(rec_mode), .rec_op_lo(rec_op_lo), .rec_op_hi(rec_op_hi),
    .rec_len(rec_len), .rec_value(rec_value), .done(done));

  always #(CLK_PERIOD/2) clk = ~clk;

  always begin
    @(negedge clk);
    #(CLK_PERIOD/4);
    if (rec_valid && rec_ready && nrec < 64) begin
      r_addr[nrec] = rec_addr; r_val[nrec] = rec_value; r_mn[nrec] = rec_mnem;
      r_md[nrec] = rec_mode; r_len[nrec] = rec_len;
      nrec++;
    end
    if (done) ndone++;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] a, input logic [7:0] b);
    in_valid = 1'b1; in_addr = a; in_byte = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [1:0] len_of(input logic [7:0] m);
    if (m == 0 || m == 4 || m == 5) return 2'd1;
    if (m == 2 || m == 9 || m == 10 || m == 12) return 2'd3;
    return 2'd2;
  endfunction

  function automatic logic [15:0] val_of(input logic [15:0] a, input logic [7:0] m,
                                         input logic [7:0] lo, input logic [7:0] hi);
    if (m == 11) return a + 16'd2 + {{8{lo[7]}}, lo};
    if (len_of(m) == 2'd3) return {hi, lo};
    if (len_of(m) == 2'd2) return {8'h00, lo};
    return 16'h0000;
  endfunction

  function automatic string tag_of(input logic [7:0] op, input logic [7:0] m);
    if (m == 0) return "R5";
    if (op[1:0] == 2'd1) return "R1";
    if (op[1:0] == 2'd0) return "R3";
    return "R4";
  endfunction

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] addrs [0:NV-1];
    logic [15:0] a;
    logic [15:0] hold_addr;
    a = 16'h1000;
    for (int i = 0; i < NV; i++) begin
      addrs[i] = a;
      a = a + {14'd0, len_of(VEC[i][7:0])};
    end
    repeat (3) @(negedge clk);
    // R8 reset state
    check(!in_ready && !rec_valid && !done, "R8", {in_ready, rec_valid, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!in_ready, "R8", in_ready, 0);

    start_addr = 16'h1000; end_addr = addrs[NV-1];
    start = 1'b1; @(negedge clk); start = 1'b0;
    send(16'h0FFE, 8'hA9);
    send(16'h0FFF, 8'h00);
    for (int i = 0; i < NV; i++) begin
      send(addrs[i], VEC[i][39:32]);
      if (len_of(VEC[i][7:0]) >= 2) send(addrs[i] + 16'd1, VEC[i][31:24]);
      if (len_of(VEC[i][7:0]) == 3) send(addrs[i] + 16'd2, VEC[i][23:16]);
    end
    repeat (5) @(negedge clk);
    check(nrec == NV, "R8", nrec, NV);
    check(ndone == 1, "R9", ndone, 1);
    check(!in_ready, "R9", in_ready, 0);
    check(r_addr[0] == 16'h1000, "R8", r_addr[0], 16'h1000);
    for (int i = 0; i < NV && i < nrec; i++) begin
      check(r_mn[i] == VEC[i][13:8] && r_md[i] == VEC[i][3:0] && r_addr[i] == addrs[i],
            tag_of(VEC[i][39:32], VEC[i][7:0]), {r_addr[i], 2'b0, r_mn[i], 4'b0, r_md[i]},
            {addrs[i], 2'b0, VEC[i][13:8], 4'b0, VEC[i][3:0]});
      check(r_len[i] == len_of(VEC[i][7:0]), "R2", r_len[i], len_of(VEC[i][7:0]));
      check(r_val[i] == val_of(addrs[i], VEC[i][7:0], VEC[i][31:24], VEC[i][23:16]),
            VEC[i][7:0] == 8'd11 ? "R7" : "R6", r_val[i],
            val_of(addrs[i], VEC[i][7:0], VEC[i][31:24], VEC[i][23:16]));
    end

    // R10 stall, R7 wrap, R9 end below start
    rec_ready = 1'b0;
    start_addr = 16'hFFFE; end_addr = 16'hFFF0;
    start = 1'b1; @(negedge clk); start = 1'b0;
    send(16'hFFFE, 8'hF0);
    send(16'hFFFF, 8'h7F);
    check(rec_valid, "R10", rec_valid, 1);
    hold_addr = rec_addr;
    for (int k = 0; k < 3; k++) begin
      in_valid = 1'b1; in_addr = 16'h0000; in_byte = 8'hEA;
      @(negedge clk);
      check(rec_valid && !in_ready && rec_addr == hold_addr && rec_value == 16'h007F,
            "R10", {rec_valid, in_ready, rec_value}, {2'b10, 16'h007F});
    end
    in_valid = 1'b0;
    rec_ready = 1'b1;
    repeat (4) @(negedge clk);
    check(nrec == NV + 1, "R10", nrec, NV + 1);
    check(r_mn[NV] == 6'd42 && r_md[NV] == 4'd11, "R3", {r_mn[NV], r_md[NV]}, {6'd42, 4'd11});
    check(r_val[NV] == 16'h007F, "R7", r_val[NV], 16'h007F);
    check(ndone == 2, "R9", ndone, 2);
    check(!in_ready, "R9", in_ready, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule